// File: doc/BRIEF.md
# Drowsy Cache Line Power Controller

This block keeps a low-voltage, contents-preserving power state for every line of a direct-mapped cache and sets the latency of each access. A free-running interval timer sends every line into the low-voltage (drowsy) state at the end of each interval, whatever the recent use of the line. No idleness is tracked. Lines come back to full supply only on demand, when an access targets them.

An access to an awake line returns after the normal hit latency. An access to a drowsy line is still a hit, because the data is retained, but the line must first be raised to full supply. The response therefore arrives a fixed wake-up penalty later and carries a slow-hit flag. The woken line stays at full supply until the next sweep. One request is in flight at a time. Per-line supply selects, a live count of low-voltage lines and two saturating event counters let the surrounding logic and software-free checks see the drowsy fraction. Tag compare, data arrays and the actual supply switches belong to the surrounding cache.

Top module: `drowsy_line_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, every bit of `line_vsel` is 1, `drowsy_lines` is 0, both counters are 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The interval timer starts at zero on reset. On the clock edge that ends each `SWEEP_CYCLES`-cycle interval (edge number `SWEEP_CYCLES`, 2x`SWEEP_CYCLES`, and so on after reset release), every line goes to the low-voltage state (`line_vsel` bit 0), including lines used just before.
- R3: A request to an awake line gives a one-cycle `rsp_valid` pulse with `rsp_slow`=0 and `rsp_idx` equal to the requested index, `HIT_LATENCY` cycles after the accept cycle (the accept cycle is the one where `req_valid` and `req_ready` are both 1).
- R4: A request to a drowsy line is answered as a hit with `rsp_slow`=1, `HIT_LATENCY`+`WAKE_CYCLES` cycles after the accept cycle. `WAKE_CYCLES` is at least 1.
- R5: A drowsy access wakes only the accessed line. From the cycle after its response that line's `line_vsel` bit is 1 and stays 1 until the next sweep, and `drowsy_lines` drops by exactly one.
- R6: `req_ready` is 0 from the cycle after acceptance up to and including the response cycle, so only one request is ever outstanding.
- R7: If a sweep edge falls while a wake-up is being counted, the access still completes as a slow hit. Afterwards the accessed line is drowsy. All other lines are drowsy from the sweep edge.
- R8: `acc_count` counts accepted requests and `slow_count` counts accepted requests to drowsy lines. Both saturate at 2^`CNT_W`-1.
- R9: `drowsy_lines` equals the number of lines whose `line_vsel` bit is 0.
- R10: During the wake-up of a drowsy line, the `line_vsel` bit of that line is 1, up to and including the response cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Controller can take a request |
| req_idx | input | IDX_W | Line index of the request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_slow | output | 1 | Response came from a drowsy line |
| rsp_idx | output | IDX_W | Line index of the response |
| line_vsel | output | NUM_LINES | Per-line supply select, 1 = full voltage |
| drowsy_lines | output | OCC_W | Lines currently at low voltage |
| acc_count | output | CNT_W | Saturating count of accepted requests |
| slow_count | output | CNT_W | Saturating count of drowsy hits |

## Verification
The main function is exercised with a table of accesses issued just after a sweep. The table mixes first touches of drowsy lines with repeat touches of already woken lines, and alternates between two lines. This separates a per-line wake from a global one and shows whether a woken line stays awake. A single access before the first sweep tells the all-awake reset state apart from the swept state. An access timed to straddle a sweep edge checks whether the wake-up and the sweep interact correctly. A run of repeated accesses past the counter limit shows whether the counters saturate or wrap.

// File: rtl/drowsy_pkg.sv
package drowsy_pkg;

   typedef enum logic [0:0] {
      ACC_IDLE = 1'b0,
      ACC_BUSY = 1'b1
   } acc_state_e;

endpackage

// File: rtl/drowsy_sweep_timer.sv
module drowsy_sweep_timer #(
   parameter int unsigned PERIOD = 4000
) (
   input  logic clk,
   input  logic rst_n,
   output logic sweep_stb
);
   localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   logic [CW-1:0] tick_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              tick_q <= '0;
      else if (tick_q == LAST) tick_q <= '0;
      else                     tick_q <= tick_q + 1'b1;
   end

   assign sweep_stb = (tick_q == LAST);
endmodule

// File: rtl/drowsy_line_bank.sv
module drowsy_line_bank #(
   parameter int unsigned NUM_LINES = 64,
   parameter int unsigned IDX_W     = 6,
   parameter int unsigned OCC_W     = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sweep_stb,
   input  logic                 wake_en,
   input  logic [IDX_W-1:0]     wake_idx,
   input  logic                 hold_en,
   input  logic [IDX_W-1:0]     hold_idx,
   output logic [NUM_LINES-1:0] drowsy_bits,
   output logic [NUM_LINES-1:0] vsel,
   output logic [OCC_W-1:0]     low_count
);
   for (genvar li = 0; li < NUM_LINES; li++) begin : g_line
      logic asleep_q;
      logic is_wake, is_hold;

      assign is_wake = wake_en && (wake_idx == IDX_W'(li));
      assign is_hold = hold_en && (hold_idx == IDX_W'(li));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         asleep_q <= 1'b0;
         else if (sweep_stb) asleep_q <= 1'b1;
         else if (is_wake)   asleep_q <= 1'b0;
      end

      assign drowsy_bits[li] = asleep_q;
      assign vsel[li]        = !asleep_q || is_hold;
   end

   always_comb begin
      low_count = '0;
      for (int k = 0; k < NUM_LINES; k++) begin
         low_count = low_count + OCC_W'(!vsel[k]);
      end
   end
endmodule

// File: rtl/drowsy_access_fsm.sv
module drowsy_access_fsm
   import drowsy_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 64,
   parameter int unsigned IDX_W       = 6,
   parameter int unsigned HIT_LATENCY = 1,
   parameter int unsigned WAKE_CYCLES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [IDX_W-1:0]     req_idx,
   input  logic [NUM_LINES-1:0] drowsy_bits,
   input  logic                 sweep_stb,
   output logic                 req_ready,
   output logic                 rsp_valid,
   output logic                 rsp_slow,
   output logic [IDX_W-1:0]     rsp_idx,
   output logic                 wake_en,
   output logic                 hold_en,
   output logic                 acc_evt,
   output logic                 slow_evt
);
   localparam int unsigned SLOW_LAT = HIT_LATENCY + WAKE_CYCLES;
   localparam int unsigned LW       = $clog2(SLOW_LAT + 1);
   localparam logic [LW-1:0] FAST_LOAD = LW'(HIT_LATENCY - 1);
   localparam logic [LW-1:0] SLOW_LOAD = LW'(SLOW_LAT - 1);

   acc_state_e       state_q;
   logic [LW-1:0]    wait_q;
   logic [IDX_W-1:0] idx_q;
   logic             slow_q;
   logic             swept_q;
   logic             accept;
   logic             target_drowsy;

   assign req_ready     = (state_q == ACC_IDLE);
   assign accept        = req_valid && req_ready;
   assign target_drowsy = drowsy_bits[req_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ACC_IDLE;
         wait_q  <= '0;
         idx_q   <= '0;
         slow_q  <= 1'b0;
         swept_q <= 1'b0;
      end else begin
         unique case (state_q)
            ACC_IDLE: begin
               if (accept) begin
                  state_q <= ACC_BUSY;
                  idx_q   <= req_idx;
                  slow_q  <= target_drowsy;
                  wait_q  <= target_drowsy ? SLOW_LOAD : FAST_LOAD;
                  swept_q <= 1'b0;
               end
            end
            ACC_BUSY: begin
               if (sweep_stb) swept_q <= 1'b1;
               if (wait_q == '0) state_q <= ACC_IDLE;
               else              wait_q  <= wait_q - 1'b1;
            end
            default: state_q <= ACC_IDLE;
         endcase
      end
   end

   assign rsp_valid = (state_q == ACC_BUSY) && (wait_q == '0);
   assign rsp_slow  = slow_q;
   assign rsp_idx   = idx_q;
   assign hold_en   = (state_q == ACC_BUSY) && slow_q;
   assign wake_en   = rsp_valid && slow_q && !swept_q && !sweep_stb;
   assign acc_evt   = accept;
   assign slow_evt  = accept && target_drowsy;
endmodule

// File: rtl/drowsy_sat_counter.sv
module drowsy_sat_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bump,
   output logic [W-1:0] value
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    value <= '0;
      else if (bump && value != TOP) value <= value + 1'b1;
   end
endmodule

// File: rtl/drowsy_line_ctrl.sv
module drowsy_line_ctrl #(
   parameter int unsigned NUM_LINES    = 64,
   parameter int unsigned SWEEP_CYCLES = 4000,
   parameter int unsigned WAKE_CYCLES  = 2,
   parameter int unsigned HIT_LATENCY  = 1,
   parameter int unsigned CNT_W        = 16,
   localparam int unsigned IDX_W       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
   localparam int unsigned OCC_W       = $clog2(NUM_LINES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [IDX_W-1:0]     req_idx,
   output logic                 rsp_valid,
   output logic                 rsp_slow,
   output logic [IDX_W-1:0]     rsp_idx,
   output logic [NUM_LINES-1:0] line_vsel,
   output logic [OCC_W-1:0]     drowsy_lines,
   output logic [CNT_W-1:0]     acc_count,
   output logic [CNT_W-1:0]     slow_count
);
   if (NUM_LINES < 2 || (1 << IDX_W) != NUM_LINES) begin : g_chk_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (WAKE_CYCLES < 1) begin : g_chk_wake
      $error("WAKE_CYCLES must be at least 1");
   end
   if (HIT_LATENCY < 1) begin : g_chk_hit
      $error("HIT_LATENCY must be at least 1");
   end
   if (SWEEP_CYCLES < 2) begin : g_chk_sweep
      $error("SWEEP_CYCLES must be at least 2");
   end
   if (CNT_W < 1) begin : g_chk_cnt
      $error("CNT_W must be at least 1");
   end

   logic                 sweep_stb;
   logic [NUM_LINES-1:0] drowsy_bits;
   logic                 wake_en;
   logic                 hold_en;
   logic                 acc_evt;
   logic                 slow_evt;

   drowsy_sweep_timer #(
      .PERIOD (SWEEP_CYCLES)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .sweep_stb (sweep_stb)
   );

   drowsy_access_fsm #(
      .NUM_LINES   (NUM_LINES),
      .IDX_W       (IDX_W),
      .HIT_LATENCY (HIT_LATENCY),
      .WAKE_CYCLES (WAKE_CYCLES)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_idx     (req_idx),
      .drowsy_bits (drowsy_bits),
      .sweep_stb   (sweep_stb),
      .req_ready   (req_ready),
      .rsp_valid   (rsp_valid),
      .rsp_slow    (rsp_slow),
      .rsp_idx     (rsp_idx),
      .wake_en     (wake_en),
      .hold_en     (hold_en),
      .acc_evt     (acc_evt),
      .slow_evt    (slow_evt)
   );

   drowsy_line_bank #(
      .NUM_LINES (NUM_LINES),
      .IDX_W     (IDX_W),
      .OCC_W     (OCC_W)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .sweep_stb   (sweep_stb),
      .wake_en     (wake_en),
      .wake_idx    (rsp_idx),
      .hold_en     (hold_en),
      .hold_idx    (rsp_idx),
      .drowsy_bits (drowsy_bits),
      .vsel        (line_vsel),
      .low_count   (drowsy_lines)
   );

   drowsy_sat_counter #(
      .W (CNT_W)
   ) u_acc_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (acc_evt),
      .value (acc_count)
   );

   drowsy_sat_counter #(
      .W (CNT_W)
   ) u_slow_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (slow_evt),
      .value (slow_count)
   );
endmodule

// File: rtl/drowsy_line_ctrl_chk.sv
module drowsy_line_ctrl_chk #(
   parameter int unsigned NUM_LINES = 64,
   parameter int unsigned IDX_W     = 6,
   parameter int unsigned OCC_W     = 7,
   parameter int unsigned CNT_W     = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_ready,
   input logic                 rsp_valid,
   input logic                 rsp_slow,
   input logic [IDX_W-1:0]     rsp_idx,
   input logic [NUM_LINES-1:0] line_vsel,
   input logic [OCC_W-1:0]     drowsy_lines,
   input logic [CNT_W-1:0]     acc_count,
   input logic [CNT_W-1:0]     slow_count,
   input logic                 sweep_stb
);
   // R6: no new request can enter while a response is pending
   a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   // R3: response is a single-cycle pulse
   a_r3_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R5: at most one line regains full voltage per cycle
   a_r5_single_wake: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(line_vsel & ~$past(line_vsel)) <= 1);

   // R10: a slow response only comes from a powered line
   a_r10_slow_powered: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_slow) |-> line_vsel[rsp_idx]);

   // R2: after a sweep at most the line being woken is still powered
   a_r2_sweep_all: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_stb |=> (drowsy_lines >= OCC_W'(NUM_LINES - 1)));

   // R8: access counter never goes backwards
   a_r8_acc_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      acc_count >= $past(acc_count));

   // R8: slow hits never exceed accesses
   a_r8_slow_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      slow_count <= acc_count);
endmodule

bind drowsy_line_ctrl drowsy_line_ctrl_chk #(
   .NUM_LINES (NUM_LINES),
   .IDX_W     (IDX_W),
   .OCC_W     (OCC_W),
   .CNT_W     (CNT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_ready    (req_ready),
   .rsp_valid    (rsp_valid),
   .rsp_slow     (rsp_slow),
   .rsp_idx      (rsp_idx),
   .line_vsel    (line_vsel),
   .drowsy_lines (drowsy_lines),
   .acc_count    (acc_count),
   .slow_count   (slow_count),
   .sweep_stb    (sweep_stb)
);

// File: tb/drowsy_line_ctrl_tb.sv
module drowsy_line_ctrl_tb;
   localparam int unsigned NL    = 16;
   localparam int unsigned SWP   = 100;
   localparam int unsigned WAKE  = 3;
   localparam int unsigned HLAT  = 2;
   localparam int unsigned CW    = 4;
   localparam int unsigned IW    = 4;
   localparam int unsigned OW    = 5;
   localparam int          CMAX  = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [IW-1:0] req_idx = '0;
   logic          rsp_valid;
   logic          rsp_slow;
   logic [IW-1:0] rsp_idx;
   logic [NL-1:0] line_vsel;
   logic [OW-1:0] drowsy_lines;
   logic [CW-1:0] acc_count;
   logic [CW-1:0] slow_count;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   int m_acc   = 0;
   int m_slow  = 0;
   int mid_low = -1;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   drowsy_line_ctrl #(
      .NUM_LINES    (NL),
      .SWEEP_CYCLES (SWP),
      .WAKE_CYCLES  (WAKE),
      .HIT_LATENCY  (HLAT),
      .CNT_W        (CW)
   ) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_idx      (req_idx),
      .rsp_valid    (rsp_valid),
      .rsp_slow     (rsp_slow),
      .rsp_idx      (rsp_idx),
      .line_vsel    (line_vsel),
      .drowsy_lines (drowsy_lines),
      .acc_count    (acc_count),
      .slow_count   (slow_count)
   );

   typedef struct packed {
      logic [3:0] idx;
      logic       slow;
      logic [4:0] low_after;
   } vec_t;

   // accesses issued right after a sweep, all 16 lines drowsy at the start
   localparam vec_t VEC [8] = '{
      '{4'd3,  1'b1, 5'd15},
      '{4'd3,  1'b0, 5'd15},
      '{4'd5,  1'b1, 5'd14},
      '{4'd3,  1'b0, 5'd14},
      '{4'd5,  1'b0, 5'd14},
      '{4'd0,  1'b1, 5'd13},
      '{4'd15, 1'b1, 5'd12},
      '{4'd0,  1'b0, 5'd12}
   };

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   task automatic check_reset_state();
      chk(line_vsel == '1, "R1 vsel", int'(line_vsel), (1 << NL) - 1);
      chk(drowsy_lines == 0, "R1 drowsy_lines", int'(drowsy_lines), 0);
      chk(acc_count == 0, "R1 acc_count", int'(acc_count), 0);
      chk(slow_count == 0, "R1 slow_count", int'(slow_count), 0);
      chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
      chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
   endtask

   // called at a negedge; returns at the negedge after the response cycle
   task automatic access(input int idx, input bit exp_slow, input bit exp_awake, input string rq);
      int n;
      int lat;
      lat = HLAT + (exp_slow ? WAKE : 0);
      req_valid = 1'b1;
      req_idx   = IW'(idx);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      n = 1;
      mid_low = -1;
      while (!rsp_valid && n < 40) begin
         chk(req_ready == 1'b0, "R6 ready low while busy", int'(req_ready), 0);
         if (exp_slow) chk(line_vsel[idx] == 1'b1, "R10 waking line powered", int'(line_vsel[idx]), 1);
         if (n == 3) mid_low = int'(drowsy_lines);
         @(negedge clk);
         n++;
      end
      if (n == 3) mid_low = int'(drowsy_lines);
      chk(n == lat, {rq, " latency"}, n, lat);
      chk(rsp_slow == exp_slow, {rq, " slow flag"}, int'(rsp_slow), int'(exp_slow));
      chk(rsp_idx == IW'(idx), "R3 rsp_idx", int'(rsp_idx), idx);
      chk(req_ready == 1'b0, "R6 ready low in response cycle", int'(req_ready), 0);
      if (exp_slow) chk(line_vsel[idx] == 1'b1, "R10 powered at response", int'(line_vsel[idx]), 1);
      m_acc  = (m_acc  < CMAX) ? m_acc + 1 : CMAX;
      if (exp_slow) m_slow = (m_slow < CMAX) ? m_slow + 1 : CMAX;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R3 pulse ends", int'(rsp_valid), 0);
      chk(line_vsel[idx] == exp_awake, "R5 line state after access", int'(line_vsel[idx]), int'(exp_awake));
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 5000, 0);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_reset_state();                       // R1 during reset
      rst_n = 1'b1;
      @(negedge clk);
      check_reset_state();                       // R1 first cycle after reset

      // R3: all lines awake before the first sweep
      access(9, 1'b0, 1'b1, "R3 fast hit");

      // R2: first sweep ends the first interval, used line included
      while (drowsy_lines != OW'(NL) && cyc < 400) @(negedge clk);
      chk(cyc == SWP, "R2 sweep edge", cyc, SWP);
      chk(line_vsel == '0, "R2 all lines low", int'(line_vsel), 0);

      // table walk: R4 drowsy hits, R3 repeat hits, R5 single-line wake
      for (int v = 0; v < 8; v++) begin
         access(int'(VEC[v].idx), VEC[v].slow, 1'b1, VEC[v].slow ? "R4 drowsy hit" : "R3 awake hit");
         chk(drowsy_lines == VEC[v].low_after, "R5 drowsy count", int'(drowsy_lines), int'(VEC[v].low_after));
      end
      chk(line_vsel == NL'(16'h8029), "R5 exactly woken lines", int'(line_vsel), 'h8029);
      chk(int'(drowsy_lines) == NL - $countones(line_vsel), "R9 count matches vsel",
          int'(drowsy_lines), NL - $countones(line_vsel));

      // R7: sweep edge at 200 falls inside the wake of line 7 accepted at edge 198
      while (cyc != 2 * SWP - 3) @(negedge clk);
      access(7, 1'b1, 1'b0, "R7 wake across sweep");
      chk(mid_low == NL - 1, "R7 others drowsy at sweep", mid_low, NL - 1);
      chk(drowsy_lines == OW'(NL), "R7 all drowsy after", int'(drowsy_lines), NL);

      // R8: exact counts so far
      chk(int'(acc_count) == m_acc, "R8 acc_count", int'(acc_count), m_acc);
      chk(int'(slow_count) == m_slow, "R8 slow_count", int'(slow_count), m_slow);

      // R8: saturation
      access(2, 1'b1, 1'b1, "R4 drowsy hit");
      for (int k = 0; k < 7; k++) access(2, 1'b0, 1'b1, "R3 awake hit");
      chk(int'(acc_count) == CMAX, "R8 acc saturates", int'(acc_count), CMAX);
      chk(int'(slow_count) == m_slow, "R8 slow_count", int'(slow_count), m_slow);

      // R1: reset in mid-run
      rst_n = 1'b0;
      #1;
      check_reset_state();
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_reset_state();

      done = 1'b1;
      summary();
      $finish;
   end
endmodule